// File: doc/BRIEF.md
# PPM Frame Transmitter

This block turns a table of per-channel interval values into a continuous pulse-position-modulated waveform on a single output line. Each slot starts with a leading edge, followed by an active pulse of fixed width. The distance from one leading edge to the next carries the value of that slot. A frame is a sync slot followed by channel slots 1 through N. N is the highest channel index the host has ever loaded. The sync slot is sized so that the frame is stretched to a minimum period where that is possible.

The host loads values through a valid/ready write stream. Each beat carries a channel index and an interval in ticks. `wr_ready` is held high at all times, so the block never applies back-pressure: a beat is consumed on every clock edge where `wr_valid` is high. A beat whose index or value is out of range is consumed and discarded. The table is copied into a working buffer only when the sequence enters the sync slot, so a frame in flight is never altered. An optional frame marker output and a polarity select are provided. All timing counts ticks, which are produced from the clock by a divide-by-`TICK_DIV` enable. The defaults give 37.5 ticks per microsecond from a 75 MHz clock.

Top module: `ppm_tx`

## Requirements
- R1: `wr_ready` is high in every cycle, including reset, and a beat is consumed on each rising clock edge where `wr_valid` is high.
- R2: A beat is accepted only if `wr_chan` is in 1..`NUM_CH` and `wr_val` is in `MIN_VAL`..`MAX_VAL` inclusive. Any other beat changes neither the table nor the channel count.
- R3: After reset every channel holds `DEF_VAL` and the channel count is 0. An accepted beat whose index is greater than the count raises the count to that index, and the count never falls.
- R4: Every slot begins with a leading edge and keeps the line active for exactly `PULSE_TICKS` ticks. A channel slot lasts exactly its value in ticks; the values `MIN_VAL` and `MAX_VAL` themselves are accepted.
- R5: Slots run in the order sync, 1, 2, …, count, then sync again. With a count of 0, only sync slots are sent.
- R6: Let S be the sum of the buffered channel values. The sync slot lasts `MIN_FRAME`−S ticks when S < `MIN_FRAME`−`MIN_SPACE`. Otherwise it lasts `MIN_SPACE` ticks with `marker_en` low, or `PULSE_TICKS` ticks with `marker_en` high.
- R7: The table, the count and the sync length are captured on the tick that starts a sync slot. A beat accepted at any other time first affects the next frame.
- R8: `frame_mark` is high exactly while slot 1 is running and `marker_en` is high, and low otherwise.
- R9: With `polarity` high the active level is 1; with `polarity` low it is 0. The inactive level is the inverse.
- R10: After reset the line sits at its inactive level and `frame_mark` is low. The first leading edge comes after `START_DELAY` ticks.
- R11: One tick occurs every `TICK_DIV` clock cycles, counted from reset release. All slot and delay lengths are counted in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat consumed (constant high) |
| wr_chan | input | CHW | Channel index, 1-based |
| wr_val | input | VAL_W | Channel interval in ticks |
| marker_en | input | 1 | Enables the frame marker and the short sync in long frames |
| polarity | input | 1 | 1 = active-high pulses, 0 = active-low |
| ppm_out | output | 1 | PPM waveform |
| frame_mark | output | 1 | High during slot 1 when enabled |

## Verification
The hardest case to reach from the ports is the long-frame sync. It needs enough channels at large values that the sum crosses the minimum-frame threshold, and it is then checked once with `marker_en` low and once with it high. In the high case the sync slot is no longer than the pulse, so two pulses abut. The stimulus fills all sixteen channels up to the maximum value and then toggles the marker enable while frames run. A second hard case is a write that lands in the middle of a frame, which must stay invisible until the next sync slot. It is reached by issuing beats at arbitrary points, unaligned to frame boundaries. A behavioural model then compares every clock cycle of the output against the expected waveform.

// File: rtl/ppm_tx_pkg.sv
package ppm_tx_pkg;
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_RUN  = 1'b1
  } seq_phase_e;
endpackage

// File: rtl/ppm_tick_gen.sv
module ppm_tick_gen #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_en
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_full
      logic unused_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unused_q <= 1'b0;
        else        unused_q <= 1'b1;
      end
      assign tick_en = 1'b1 | unused_q;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
      end
      assign tick_en = (div_q == DW'(TICK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ppm_chan_table.sv
module ppm_chan_table #(
  parameter int NUM_CH  = 16,
  parameter int VAL_W   = 32,
  parameter int CHW     = 5,
  parameter int MIN_VAL = 11250,
  parameter int MAX_VAL = 93750,
  parameter int DEF_VAL = 56250
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [CHW-1:0]               wr_chan,
  input  logic [VAL_W-1:0]             wr_val,
  output logic [NUM_CH-1:0][VAL_W-1:0] tbl_o,
  output logic [CHW-1:0]               count_o,
  output logic [VAL_W-1:0]             sum_o
);
  logic                         accept;
  logic [NUM_CH-1:0][VAL_W-1:0] tbl_q;
  logic [CHW-1:0]               count_q;

  // legality filter on the incoming beat
  always_comb begin
    accept = wr_valid
           && (wr_chan != '0)
           && (wr_chan <= CHW'(NUM_CH))
           && (wr_val >= VAL_W'(MIN_VAL))
           && (wr_val <= VAL_W'(MAX_VAL));
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          tbl_q[g] <= VAL_W'(DEF_VAL);
        else if (accept && (wr_chan == CHW'(g + 1)))
          tbl_q[g] <= wr_val;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (accept && (wr_chan > count_q))
      count_q <= wr_chan;
  end

  // sum of the channels that belong to the frame
  always_comb begin
    logic [VAL_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (i < int'(count_q)) acc = acc + tbl_q[i];
    end
    sum_o = acc;
  end

  assign tbl_o   = tbl_q;
  assign count_o = count_q;
endmodule

// File: rtl/ppm_frame_seq.sv
module ppm_frame_seq
  import ppm_tx_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int VAL_W       = 32,
  parameter int CHW         = 5,
  parameter int PULSE_TICKS = 3750,
  parameter int MIN_FRAME   = 750000,
  parameter int MIN_SPACE   = 187500,
  parameter int START_DELAY = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_en,
  input  logic                         marker_en,
  input  logic                         polarity,
  input  logic [NUM_CH-1:0][VAL_W-1:0] tbl_i,
  input  logic [CHW-1:0]               count_i,
  input  logic [VAL_W-1:0]             sum_i,
  output logic                         ppm_out,
  output logic                         frame_mark,
  output logic                         running_o,
  output logic [CHW-1:0]               slot_o,
  output logic [CHW-1:0]               snap_cnt_o
);
  localparam int DLY_W = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
  localparam logic [VAL_W-1:0] SHORT_LIM = VAL_W'(MIN_FRAME - MIN_SPACE);

  seq_phase_e                   phase_q;
  logic [DLY_W-1:0]             dly_q;
  logic [CHW-1:0]               slot_q;
  logic [VAL_W-1:0]             cnt_q;
  logic [NUM_CH-1:0][VAL_W-1:0] snap_tbl_q;
  logic [CHW-1:0]               snap_cnt_q;
  logic [VAL_W-1:0]             snap_sync_q;

  logic [VAL_W-1:0] sync_len;
  logic [VAL_W-1:0] period;
  logic             dly_done;
  logic             slot_end;
  logic             slot_last;
  logic             take_snap;
  logic             pulse_on;

  // sync slot length from the live table
  always_comb begin
    if (sum_i < SHORT_LIM)
      sync_len = VAL_W'(MIN_FRAME) - sum_i;
    else if (marker_en)
      sync_len = VAL_W'(PULSE_TICKS);
    else
      sync_len = VAL_W'(MIN_SPACE);
  end

  // length of the running slot from the buffered copy
  always_comb begin
    period = snap_sync_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (slot_q == CHW'(i + 1)) period = snap_tbl_q[i];
    end
  end

  assign dly_done  = (dly_q == DLY_W'(START_DELAY - 1));
  assign slot_end  = (cnt_q == period - 1'b1);
  assign slot_last = (slot_q == snap_cnt_q);
  assign take_snap = tick_en && (((phase_q == PH_WAIT) && dly_done)
                              || ((phase_q == PH_RUN) && slot_end && slot_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      dly_q   <= '0;
      slot_q  <= '0;
      cnt_q   <= '0;
    end else if (tick_en) begin
      case (phase_q)
        PH_WAIT: begin
          if (dly_done) begin
            phase_q <= PH_RUN;
            slot_q  <= '0;
            cnt_q   <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: begin
          if (slot_end) begin
            cnt_q  <= '0;
            slot_q <= slot_last ? '0 : slot_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // frame-boundary capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_tbl_q  <= '0;
      snap_cnt_q  <= '0;
      snap_sync_q <= VAL_W'(MIN_FRAME);
    end else if (take_snap) begin
      snap_tbl_q  <= tbl_i;
      snap_cnt_q  <= count_i;
      snap_sync_q <= sync_len;
    end
  end

  assign pulse_on   = (phase_q == PH_RUN) && (cnt_q < VAL_W'(PULSE_TICKS));
  assign ppm_out    = polarity ? pulse_on : !pulse_on;
  assign frame_mark = marker_en && (phase_q == PH_RUN) && (slot_q == CHW'(1));
  assign running_o  = (phase_q == PH_RUN);
  assign slot_o     = slot_q;
  assign snap_cnt_o = snap_cnt_q;
endmodule

// File: rtl/ppm_tx.sv
module ppm_tx #(
  parameter int TICK_DIV    = 2,
  parameter int NUM_CH      = 16,
  parameter int VAL_W       = 32,
  parameter int PULSE_TICKS = 3750,
  parameter int MIN_VAL     = 11250,
  parameter int MAX_VAL     = 93750,
  parameter int DEF_VAL     = 56250,
  parameter int MIN_FRAME   = 750000,
  parameter int MIN_SPACE   = 187500,
  parameter int START_DELAY = 8,
  localparam int CHW        = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CHW-1:0]   wr_chan,
  input  logic [VAL_W-1:0] wr_val,
  input  logic             marker_en,
  input  logic             polarity,
  output logic             ppm_out,
  output logic             frame_mark
);
  logic                         tick_en;
  logic [NUM_CH-1:0][VAL_W-1:0] tbl;
  logic [CHW-1:0]               chan_cnt;
  logic [VAL_W-1:0]             chan_sum;
  logic                         running;
  logic [CHW-1:0]               slot;
  logic [CHW-1:0]               snap_cnt;

  assign wr_ready = 1'b1;

  ppm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en)
  );

  ppm_chan_table #(
    .NUM_CH (NUM_CH), .VAL_W (VAL_W), .CHW (CHW),
    .MIN_VAL(MIN_VAL), .MAX_VAL(MAX_VAL), .DEF_VAL(DEF_VAL)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_chan  (wr_chan),
    .wr_val   (wr_val),
    .tbl_o    (tbl),
    .count_o  (chan_cnt),
    .sum_o    (chan_sum)
  );

  ppm_frame_seq #(
    .NUM_CH (NUM_CH), .VAL_W (VAL_W), .CHW (CHW),
    .PULSE_TICKS(PULSE_TICKS), .MIN_FRAME(MIN_FRAME),
    .MIN_SPACE(MIN_SPACE), .START_DELAY(START_DELAY)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .marker_en  (marker_en),
    .polarity   (polarity),
    .tbl_i      (tbl),
    .count_i    (chan_cnt),
    .sum_i      (chan_sum),
    .ppm_out    (ppm_out),
    .frame_mark (frame_mark),
    .running_o  (running),
    .slot_o     (slot),
    .snap_cnt_o (snap_cnt)
  );
endmodule

// File: rtl/ppm_tx_chk.sv
module ppm_tx_chk #(
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic [CHW-1:0] wr_chan,
  input logic           marker_en,
  input logic           polarity,
  input logic           ppm_out,
  input logic           frame_mark,
  input logic           tick_en,
  input logic           running,
  input logic [CHW-1:0] slot,
  input logic [CHW-1:0] snap_cnt,
  input logic [CHW-1:0] chan_cnt
);
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (ppm_out == !polarity));

  // R8
  mark_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> (marker_en && running));

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_en) && $stable(polarity)) |-> $stable(ppm_out));

  // R5
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> $past(tick_en));

  // R3
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_cnt >= $past(chan_cnt));

  // R7
  snap_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cnt != $past(snap_cnt)) |-> (slot == '0));

  // R2
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_chan == '0)) |=> $stable(chan_cnt));
endmodule

bind ppm_tx ppm_tx_chk #(.CHW(CHW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_chan    (wr_chan),
  .marker_en  (marker_en),
  .polarity   (polarity),
  .ppm_out    (ppm_out),
  .frame_mark (frame_mark),
  .tick_en    (tick_en),
  .running    (running),
  .slot       (slot),
  .snap_cnt   (snap_cnt),
  .chan_cnt   (chan_cnt)
);

// File: tb/ppm_tx_bench.sv
`timescale 1ns/1ps
module ppm_tx_bench;
  localparam int D     = 2;
  localparam int NCH   = 16;
  localparam int VW    = 32;
  localparam int PW    = 3;
  localparam int VMIN  = 8;
  localparam int VMAX  = 40;
  localparam int VDEF  = 20;
  localparam int FRAME = 200;
  localparam int SPACE = 50;
  localparam int SD    = 4;
  localparam int CW    = $clog2(NCH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [CW-1:0] wr_chan = '0;
  logic [VW-1:0] wr_val = '0;
  logic          marker_en = 1'b0;
  logic          polarity = 1'b1;
  logic          ppm_out;
  logic          frame_mark;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  ppm_tx #(
    .TICK_DIV(D), .NUM_CH(NCH), .VAL_W(VW), .PULSE_TICKS(PW),
    .MIN_VAL(VMIN), .MAX_VAL(VMAX), .DEF_VAL(VDEF),
    .MIN_FRAME(FRAME), .MIN_SPACE(SPACE), .START_DELAY(SD)
  ) u_ppm_tx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_val(wr_val), .marker_en(marker_en),
    .polarity(polarity), .ppm_out(ppm_out), .frame_mark(frame_mark)
  );

  // behavioural reference: a queue of slot lengths per frame
  int m_ph, m_dly, m_cnt, m_idx, m_el;
  bit m_run;
  int m_tab[1:NCH];
  int q[$];

  function automatic void begin_frame();
    int s = 0;
    int sync;
    for (int c = 1; c <= m_cnt; c++) s += m_tab[c];
    if (s < FRAME - SPACE) sync = FRAME - s;
    else if (marker_en)    sync = PW;
    else                   sync = SPACE;
    q.delete();
    q.push_back(sync);
    for (int c = 1; c <= m_cnt; c++) q.push_back(m_tab[c]);
    m_idx = 0;
    m_el  = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_dly = 0; m_cnt = 0; m_idx = 0; m_el = 0; m_run = 0;
      for (int c = 1; c <= NCH; c++) m_tab[c] = VDEF;
      q.delete();
    end else begin
      bit tick;
      tick = (m_ph == D - 1);
      m_ph = (m_ph + 1) % D;
      if (tick) begin
        if (!m_run) begin
          m_dly++;
          if (m_dly == SD) begin
            m_run = 1;
            begin_frame();
          end
        end else begin
          m_el++;
          if (m_el == q[m_idx]) begin
            m_el = 0;
            m_idx++;
            if (m_idx == q.size()) begin_frame();
          end
        end
      end
      // R2: only legal beats land in the table
      if (wr_valid && wr_chan >= 1 && int'(wr_chan) <= NCH &&
          int'(wr_val) >= VMIN && int'(wr_val) <= VMAX) begin
        m_tab[int'(wr_chan)] = int'(wr_val);
        if (int'(wr_chan) > m_cnt) m_cnt = int'(wr_chan);
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    bit exp_act, exp_out, exp_mark;
    exp_act  = m_run && (m_el < PW);
    exp_out  = polarity ? exp_act : !exp_act;
    exp_mark = marker_en && m_run && (m_idx == 1);
    n_cmp++;
    if (ppm_out !== exp_out || frame_mark !== exp_mark) begin
      n_bad++;
      $display("FAIL %s t=%0t out/mark actual=%b%b expected=%b%b",
               tag, $time, ppm_out, frame_mark, exp_out, exp_mark);
    end
    if (wr_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 wr_ready actual=%b expected=1", wr_ready);
    end
  end

  task automatic put(input int ch, input int val);
    @(posedge clk); #1;
    wr_valid = 1'b1;
    wr_chan  = CW'(ch);
    wr_val   = VW'(val);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    run(3);
    // R10: reset state checked by the per-cycle compare
    @(posedge clk); #1 rst_n = 1'b1;
    // R11: tick pacing and start delay with an empty channel set
    tag = "R11";
    run(600);
    // R3: partial table, default fills channel 2
    tag = "R3";
    put(1, 30);
    put(3, 12);
    run(700);
    // R7: a beat in the middle of a frame
    tag = "R7";
    run(37);
    put(2, 25);
    run(800);
    // R2: illegal index and value beats
    tag = "R2";
    put(0, 20);
    put(17, 20);
    put(2, VMIN - 1);
    put(3, VMAX + 1);
    run(600);
    // R4: boundary values accepted
    tag = "R4";
    put(4, VMIN);
    put(5, VMAX);
    run(800);
    // R6: long frame with the wide sync
    tag = "R6";
    for (int c = 6; c <= NCH; c++) put(c, VMAX);
    run(1600);
    // R8: marker on, short sync in long frames
    tag = "R8";
    @(posedge clk); #1 marker_en = 1'b1;
    run(1600);
    // R5: shrink the sum back under the threshold
    tag = "R5";
    @(posedge clk); #1 marker_en = 1'b0;
    for (int c = 1; c <= NCH; c++) put(c, VMIN);
    run(1200);
    // R9: active-low output
    tag = "R9";
    @(posedge clk); #1 polarity = 1'b0;
    run(1200);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule